// File: doc/BRIEF.md
# Parallel PRBS31 Pattern Generator

This block is the data source of a memory stress tester. It runs a 31-bit maximal-length LFSR whose feedback polynomial is x^31 + x^18 + 1. On every beat that the consumer accepts, it moves that register forward by several serial steps in one clock cycle. The newly generated bits appear on a narrow registered bus. The same bus is also copied across a wide memory write word.

The consumer raises `valid_i` in each cycle in which it takes a word, for example its memory write enable. In all other cycles the pattern holds, so stalls cannot make the sequence skip values or repeat them. A one-cycle `start_i` pulse restarts the sequence from the seed on `seed_i`. A checker on the read side can rebuild the expected stream from the same seed.

Top module: `prbs31_pattern_gen`

## Requirements
- R1: While `rst` is high, at a rising clock edge, `beat_o` and `word_o` become zero. The state becomes 31'h5F26B8D9, so the first accepted beat after reset carries the first bits of the sequence that starts from that value.
- R2: One serial step of the state s[30:0] works as follows. It forms fb = s[30] XOR s[17]. The next state is {s[29:0], fb}, and fb is the generated bit.
- R3: Each accepted beat performs BEAT_W (default 8) serial steps. The first bit generated goes to `beat_o[BEAT_W-1]` and the last goes to `beat_o[0]`.
- R4: The bits of a beat accepted at one rising edge appear on `beat_o` after that edge and stay there until the next accepted beat or start.
- R5: At an edge where `valid_i` and `start_i` are both low, neither the state nor `beat_o` changes.
- R6: At an edge where `start_i` is high, the state loads `seed_i` and `beat_o` clears to zero.
- R7: A start with `seed_i` equal to zero loads 31'h5F26B8D9 instead of zero. The state is never all-zero outside reset.
- R8: When `start_i` and `valid_i` are high at the same edge, the start takes effect and no beat is generated.
- R9: `word_o` holds WORD_W/BEAT_W copies of `beat_o`. Byte lane k, bits [8k+7:8k] in the default configuration, always equals `beat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Restart pulse; loads the seed |
| seed_i | input | 31 | Seed loaded on start (zero selects the default) |
| valid_i | input | 1 | Consumer accepts a beat this cycle |
| beat_o | output | BEAT_W (8) | Newest generated bits |
| word_o | output | WORD_W (512) | `beat_o` replicated across the memory word |

## Verification
A restart and a beat acceptance can fall in the same cycle. The bench provokes this by raising `start_i` while `valid_i` is held high in the middle of continuous streaming, once with a nonzero seed and once with a zero seed. The behavioural reference judges the collision. It discards the beat, reloads its bit history from the seed, expects a cleared output, and then expects the following accepted beats to start exactly at the seed's sequence. It compares this against `beat_o` and every lane of `word_o` on every clock.

// File: rtl/prbs31_pkg.sv
package prbs31_pkg;
  localparam int STATE_W = 31;
  localparam int TAP_HI  = 30;
  localparam int TAP_LO  = 17;
  localparam logic [STATE_W-1:0] DEFAULT_SEED = 31'h5F26B8D9;

  // feedback bit of one serial step (x^31 + x^18 + 1)
  function automatic logic prbs_fb(input logic [STATE_W-1:0] s);
    return s[TAP_HI] ^ s[TAP_LO];
  endfunction

  // state after one serial step
  function automatic logic [STATE_W-1:0] prbs_next(input logic [STATE_W-1:0] s);
    return {s[STATE_W-2:0], prbs_fb(s)};
  endfunction

  // seed actually loaded: zero is replaced to avoid lock-up
  function automatic logic [STATE_W-1:0] seed_fix(input logic [STATE_W-1:0] s);
    return (s == '0) ? DEFAULT_SEED : s;
  endfunction
endpackage

// File: rtl/prbs31_unroll.sv
module prbs31_unroll
  import prbs31_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o,
  output logic [BEAT_W-1:0]  bits_o
);
  logic [STATE_W-1:0] stage [BEAT_W+1];

  assign stage[0] = state_i;

  for (genvar k = 0; k < BEAT_W; k++) begin : g_step
    assign stage[k+1]          = prbs_next(stage[k]);
    assign bits_o[BEAT_W-1-k]  = prbs_fb(stage[k]);
  end

  assign state_o = stage[BEAT_W];
endmodule

// File: rtl/prbs31_core.sv
module prbs31_core
  import prbs31_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic               valid_i,
  output logic [BEAT_W-1:0]  beat_o
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_adv;
  logic [BEAT_W-1:0]  bits_adv;
  logic [BEAT_W-1:0]  beat_q;
  logic               load_ev;
  logic               step_ev;

  // named events for the assertions
  assign load_ev = start_i;
  assign step_ev = valid_i && !start_i;

  prbs31_unroll #(.BEAT_W(BEAT_W)) u_unroll (
    .state_i (state_q),
    .state_o (state_adv),
    .bits_o  (bits_adv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DEFAULT_SEED;
      beat_q  <= '0;
    end else if (load_ev) begin
      state_q <= seed_fix(seed_i);
      beat_q  <= '0;
    end else if (step_ev) begin
      state_q <= state_adv;
      beat_q  <= bits_adv;
    end
  end

  assign beat_o = beat_q;

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !valid_i) |=> ($stable(state_q) && $stable(beat_q)));

  // R6
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (beat_q == '0));

  // R6
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && seed_i != '0) |=> (state_q == $past(seed_i)));

  // R7
  no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R3
  beat_advances_chk: assert property (@(posedge clk) disable iff (rst)
    step_ev |=> (state_q != $past(state_q)));
endmodule

// File: rtl/prbs31_fanout.sv
module prbs31_fanout #(
  parameter int BEAT_W = 8,
  parameter int WORD_W = 512
) (
  input  logic [BEAT_W-1:0] beat_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int COPIES = WORD_W / BEAT_W;

  for (genvar c = 0; c < COPIES; c++) begin : g_lane
    assign word_o[c*BEAT_W +: BEAT_W] = beat_i;
  end

  if (COPIES * BEAT_W < WORD_W) begin : g_pad
    assign word_o[WORD_W-1:COPIES*BEAT_W] = '0;
  end
endmodule

// File: rtl/prbs31_pattern_gen.sv
module prbs31_pattern_gen
  import prbs31_pkg::*;
#(
  parameter int BEAT_W = 8,
  parameter int WORD_W = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [STATE_W-1:0] seed_i,
  input  logic               valid_i,
  output logic [BEAT_W-1:0]  beat_o,
  output logic [WORD_W-1:0]  word_o
);
  logic [BEAT_W-1:0] beat_w;

  prbs31_core #(.BEAT_W(BEAT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .seed_i  (seed_i),
    .valid_i (valid_i),
    .beat_o  (beat_w)
  );

  prbs31_fanout #(.BEAT_W(BEAT_W), .WORD_W(WORD_W)) u_fanout (
    .beat_i (beat_w),
    .word_o (word_o)
  );

  assign beat_o = beat_w;

  // R9
  lane_low_match_chk: assert property (@(posedge clk) disable iff (rst)
    word_o[BEAT_W-1:0] == beat_o);

  // R8
  start_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && valid_i) |=> (beat_o == '0));
endmodule

// File: tb/prbs31_pattern_gen_test.sv
module prbs31_pattern_gen_test;
  localparam int BW = 8;
  localparam int WW = 512;
  localparam logic [30:0] DEF = 31'h5F26B8D9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [30:0]   seed_i = '0;
  logic          valid_i = 1'b0;
  logic [BW-1:0] beat_o;
  logic [WW-1:0] word_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference: history of generated bits, index 0 is the newest
  bit q[$];
  logic [BW-1:0] exp_beat;

  prbs31_pattern_gen #(.BEAT_W(BW), .WORD_W(WW)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .seed_i(seed_i),
    .valid_i(valid_i), .beat_o(beat_o), .word_o(word_o)
  );

  always #2.5 clk = ~clk;

  task automatic load_hist(input logic [30:0] s);
    q.delete();
    for (int i = 0; i < 31; i++) q.push_back(s[i]);
  endtask

  // model update at each edge, using inputs that were set at the prior falling edge
  always @(posedge clk) begin
    if (rst) begin
      load_hist(DEF);
      exp_beat = '0;
    end else if (start_i) begin
      load_hist(seed_i == 0 ? DEF : seed_i);
      exp_beat = '0;
    end else if (valid_i) begin
      for (int k = 0; k < BW; k++) begin
        bit nb;
        nb = q[30] ^ q[17];
        q.push_front(nb);
        void'(q.pop_back());
        exp_beat[BW-1-k] = nb;
      end
    end
  end

  task automatic check(input string r, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && q.size() == 31) begin
      check(tag, {{(WW-BW){1'b0}}, beat_o}, {{(WW-BW){1'b0}}, exp_beat});
      check("R9", word_o, {(WW/BW){exp_beat}});
    end
  end

  task automatic drive(input bit st, input bit vd, input logic [30:0] sd);
    @(negedge clk);
    start_i = st; valid_i = vd; seed_i = sd;
  endtask

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {{(WW-BW){1'b0}}, beat_o}, '0);
    check("R1", word_o, '0);
    rst = 1'b0;
    // R2 R3 R4: continuous streaming from the default seed
    tag = "R3";
    for (int i = 0; i < 40; i++) drive(0, 1, 31'h0);
    // R5: irregular gaps, held output
    tag = "R5";
    for (int i = 0; i < 60; i++) drive(0, (i % 3) != 1 && (i % 7) != 0, 31'h0);
    for (int i = 0; i < 10; i++) drive(0, 0, 31'h0);
    // R6: restart with a nonzero seed
    tag = "R6";
    drive(1, 0, 31'h1234567);
    for (int i = 0; i < 30; i++) drive(0, 1, 31'h0);
    // R8: start and valid together while streaming
    tag = "R8";
    drive(1, 1, 31'h7ACE0F11);
    drive(0, 1, 31'h0);
    drive(0, 1, 31'h0);
    for (int i = 0; i < 30; i++) drive(0, i[0], 31'h0);
    // R7: zero seed loads the default
    tag = "R7";
    drive(1, 1, 31'h0);
    for (int i = 0; i < 40; i++) drive(0, 1, 31'h0);
    // R2: long run to cover the bit history well beyond 31 steps
    tag = "R2";
    for (int i = 0; i < 100; i++) drive(0, (i % 5) != 2, 31'h0);
    // R1: reset mid-stream, then resume
    tag = "R1";
    drive(0, 1, 31'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", {{(WW-BW){1'b0}}, beat_o}, '0);
    for (int i = 0; i < 20; i++) drive(0, 1, 31'h0);
    drive(0, 0, 31'h0);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule